// File: doc/BRIEF.md
# AES-128 Table-Lookup Encryption Engine

This block encrypts one 128-bit block under a 128-bit key with the AES-128 cipher. It works iteratively and computes one full round per clock. Byte substitution, the row rotation and the column mixing are merged into one precomputed 256-entry by 32-bit table. The three other per-row tables are byte rotations of that table, so they are produced by wiring. The byte shuffle between rounds is also fixed wiring. A round therefore reduces to sixteen table reads, an XOR tree per column, and the XOR with the round key. The table holds its entries as constants, and the S-box value is taken from the middle bytes of each word. The round keys are derived one per clock, alongside the data path, and are never stored as a full schedule.

Plaintext and key enter together on a valid/ready input stream. The ciphertext leaves on a valid/ready output stream. Back-pressure rules:
- A new block is accepted only while the engine is idle and no result is waiting, or in the cycle the waiting result is taken.
- A result that is not yet taken holds its value indefinitely.
- Data offered on the input while the engine is not ready is ignored.

Top module: `aes_tt_core`

## Requirements
- R1: While reset is asserted, and directly after it, `out_valid` is 0 and `in_ready` is 1.
- R2: After a block is accepted, `in_ready` stays 0 until the result is presented. It also stays 0 while `out_valid` is 1 and `out_ready` is 0.
- R3: A block is accepted on a rising edge where both `in_valid` and `in_ready` are 1. `out_valid` rises on the 10th rising edge after that edge.
- R4: `out_text` is the AES-128 encryption of `in_text` under `in_key`. Byte 0 of each 128-bit vector sits in bits [127:120], and the state is filled column by column. Plaintext 00112233445566778899aabbccddeeff with key 000102030405060708090a0b0c0d0e0f gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_text` does not change.
- R6: In a cycle where `out_valid` and `out_ready` are both 1, `in_ready` is 1. A new block offered in that cycle is accepted on the same edge on which the result is taken.
- R7: Input data presented with `in_valid` while `in_ready` is 0 has no effect on the result in flight.
- R8: Arbitrary keys and plaintexts give ciphertexts that match a bytewise reference. That reference uses round constants 01 up to 36, doubled in GF(2^8) modulo x^8+x^4+x^3+x+1, and omits column mixing in round 10. This must hold under random output back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Plaintext and key are offered |
| in_ready | output | 1 | Engine can take a block this cycle |
| in_text | input | 128 | Plaintext block, byte 0 in MSBs |
| in_key | input | 128 | Cipher key, byte 0 in MSBs |
| out_valid | output | 1 | Ciphertext is presented |
| out_ready | input | 1 | Consumer takes the ciphertext |
| out_text | output | 128 | Ciphertext block, byte 0 in MSBs |

## Verification
Two handshakes can coincide on one edge: a waiting result is taken, and a fresh block is accepted. The bench provokes this by holding `out_ready` low with a result waiting and a new block offered, then raising `out_ready`. It judges that `in_ready` rises in that same cycle. It then checks that on the next cycle the old result is gone while the engine is busy with the new block, and that the new block's ciphertext is correct. A cycle-level reference model also covers the same overlap under random back-pressure, on every clock.

// File: rtl/aes_tt_pkg.sv
package aes_tt_pkg;

  // Multiply by x modulo x^8+x^4+x^3+x+1.
  function automatic logic [7:0] gf_x2(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] aa;
    acc = 8'h00;
    aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = gf_x2(aa);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  // Inverse as a^254 (zero maps to zero), then the affine map.
  function automatic logic [7:0] sub_byte(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] inv;
    sq  = a;
    inv = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq  = gf_mul(sq, sq);
      inv = gf_mul(inv, sq);
    end
    return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
  endfunction

  // Row-0 table word: {2*S, S, S, 3*S}, row 0 in the most significant byte.
  function automatic logic [31:0] tword(input logic [7:0] a);
    logic [7:0] s;
    s = sub_byte(a);
    return {gf_x2(s), s, s, gf_x2(s) ^ s};
  endfunction

endpackage

// File: rtl/aes_tt_rom.sv
module aes_tt_rom #(
  parameter int N_LOOK = 20
) (
  input  logic [N_LOOK*8-1:0]  idx,
  output logic [N_LOOK*32-1:0] word
);
  localparam int ENTRIES = 256;

  logic [31:0] tab [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign tab[e] = aes_tt_pkg::tword(8'(e));
  end

  for (genvar p = 0; p < N_LOOK; p++) begin : g_port
    assign word[p*32 +: 32] = tab[idx[p*8 +: 8]];
  end
endmodule

// File: rtl/aes_tt_round.sv
module aes_tt_round #(
  parameter int NCOL = 4
) (
  input  logic [NCOL*4*32-1:0] tw,     // lookup words, port 4*c+r
  input  logic                 last,
  input  logic [NCOL*32-1:0]   rkey,
  output logic [NCOL*32-1:0]   nxt
);
  localparam int W = NCOL * 32;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic [31:0] w0, w1, w2, w3, mixed, subst;
    assign w0 = tw[(4*c+0)*32 +: 32];
    assign w1 = tw[(4*c+1)*32 +: 32];
    assign w2 = tw[(4*c+2)*32 +: 32];
    assign w3 = tw[(4*c+3)*32 +: 32];
    // Rows 1..3 use the base word rotated right by 8, 16, 24 bits.
    assign mixed = w0 ^ {w1[7:0], w1[31:8]} ^ {w2[15:0], w2[31:16]} ^ {w3[23:0], w3[31:24]};
    assign subst = {w0[23:16], w1[23:16], w2[23:16], w3[23:16]};
    assign nxt[W-1-32*c -: 32] = (last ? subst : mixed) ^ rkey[W-1-32*c -: 32];
  end
endmodule

// File: rtl/aes_tt_keystep.sv
module aes_tt_keystep (
  input  logic [127:0] rk_in,
  input  logic [7:0]   rcon,
  input  logic [31:0]  sw,      // substituted bytes of the rotated last word
  output logic [127:0] rk_out
);
  logic [31:0] k0, k1, k2, k3, n0, n1, n2, n3;

  assign {k0, k1, k2, k3} = rk_in;
  assign n0 = k0 ^ sw ^ {rcon, 24'h000000};
  assign n1 = k1 ^ n0;
  assign n2 = k2 ^ n1;
  assign n3 = k3 ^ n2;
  assign rk_out = {n0, n1, n2, n3};
endmodule

// File: rtl/aes_tt_core.sv
module aes_tt_core #(
  parameter int NROUNDS = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [127:0] in_text,
  input  logic [127:0] in_key,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [127:0] out_text
);
  localparam int NCOL   = 4;
  localparam int NB     = NCOL * 4;
  localparam int BLK    = NB * 8;
  localparam int N_LOOK = NB + 4;
  localparam int CW     = $clog2(NROUNDS + 1);

  logic [BLK-1:0]       st_q, rk_q, rk_nxt, rnd_out;
  logic [7:0]           rcon_q;
  logic [CW-1:0]        rnd_q;
  logic                 busy_q, ov_q, accept, last;
  logic [N_LOOK*8-1:0]  idx;
  logic [N_LOOK*32-1:0] word;
  logic [31:0]          ksub;

  assign in_ready  = !busy_q && (!ov_q || out_ready);
  assign accept    = in_valid && in_ready;
  assign last      = (rnd_q == CW'(NROUNDS));
  assign out_valid = ov_q;
  assign out_text  = st_q;

  // Row shift as wiring: port 4c+r reads row r of column (c+r) mod 4.
  always_comb begin
    for (int c = 0; c < NCOL; c++) begin
      for (int r = 0; r < 4; r++) begin
        idx[(4*c+r)*8 +: 8] = st_q[BLK-1-8*(4*((c+r)%NCOL)+r) -: 8];
      end
    end
    idx[(NB+0)*8 +: 8] = rk_q[23:16];
    idx[(NB+1)*8 +: 8] = rk_q[15:8];
    idx[(NB+2)*8 +: 8] = rk_q[7:0];
    idx[(NB+3)*8 +: 8] = rk_q[31:24];
  end

  for (genvar k = 0; k < 4; k++) begin : g_ksub
    assign ksub[31-8*k -: 8] = word[(NB+k)*32+16 +: 8];
  end

  aes_tt_rom #(.N_LOOK(N_LOOK)) rom_i (
    .idx  (idx),
    .word (word)
  );

  aes_tt_keystep key_i (
    .rk_in  (rk_q),
    .rcon   (rcon_q),
    .sw     (ksub),
    .rk_out (rk_nxt)
  );

  aes_tt_round #(.NCOL(NCOL)) round_i (
    .tw   (word[NB*32-1:0]),
    .last (last),
    .rkey (rk_nxt),
    .nxt  (rnd_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      rk_q   <= '0;
      rcon_q <= 8'h01;
      rnd_q  <= '0;
      busy_q <= 1'b0;
      ov_q   <= 1'b0;
    end else begin
      if (ov_q && out_ready) ov_q <= 1'b0;
      if (accept) begin
        st_q   <= in_text ^ in_key;
        rk_q   <= in_key;
        rcon_q <= 8'h01;
        rnd_q  <= CW'(1);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        st_q   <= rnd_out;
        rk_q   <= rk_nxt;
        rcon_q <= aes_tt_pkg::gf_x2(rcon_q);
        if (last) begin
          busy_q <= 1'b0;
          ov_q   <= 1'b1;
        end else begin
          rnd_q <= rnd_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/aes_tt_chk.sv
module aes_tt_chk #(
  parameter int NROUNDS = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [127:0] out_text
);
  logic       run;
  logic [7:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (in_valid && in_ready) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run) begin
      if (cnt != 8'hFF) cnt <= cnt + 8'd1;
      if (out_valid) run <= 1'b0;
    end
  end

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (run && cnt == 8'(NROUNDS)));

  assert_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !out_valid) |-> !in_ready);

  assert_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_text)));

  assert_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> in_ready);
endmodule

bind aes_tt_core aes_tt_chk #(.NROUNDS(NROUNDS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_text  (out_text)
);

// File: tb/aes_tt_core_tb_top.sv
module aes_tt_core_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b0;
  logic [127:0] in_text = '0;
  logic [127:0] in_key = '0;
  logic         in_ready, out_valid;
  logic [127:0] out_text;

  always #4 clk = ~clk;

  aes_tt_core dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_text(in_text), .in_key(in_key), .out_valid(out_valid),
    .out_ready(out_ready), .out_text(out_text)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;
  bit rand_rdy = 0;
  logic [7:0] sbx [256];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] xt(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= a;
      a = xt(a);
    end
    return p;
  endfunction

  task automatic init_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 0;
      logic [7:0] s;
      for (int y = 1; y < 256; y++) if (gm(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      s = inv ^ 8'h63;
      for (int k = 1; k < 5; k++) s ^= (inv << k) | (inv >> (8 - k));
      sbx[x] = s;
    end
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [127:0] key);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] w [176];
    logic [7:0] tmp [4];
    logic [7:0] rc = 8'h01;
    logic [127:0] res;
    for (int i = 0; i < 16; i++) w[i] = key[127-8*i -: 8];
    for (int i = 16; i < 176; i += 4) begin
      for (int j = 0; j < 4; j++) tmp[j] = w[i-4+j];
      if (i % 16 == 0) begin
        logic [7:0] t0 = tmp[0];
        tmp[0] = sbx[tmp[1]] ^ rc; tmp[1] = sbx[tmp[2]];
        tmp[2] = sbx[tmp[3]];      tmp[3] = sbx[t0];
        rc = xt(rc);
      end
      for (int j = 0; j < 4; j++) w[i+j] = w[i-16+j] ^ tmp[j];
    end
    for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ w[i];
    for (int rd = 1; rd <= 10; rd++) begin
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) t[r+4*c] = sbx[s[r+4*((c+r)%4)]];
      for (int c = 0; c < 4; c++) begin
        logic [7:0] a0 = t[4*c], a1 = t[4*c+1], a2 = t[4*c+2], a3 = t[4*c+3];
        if (rd < 10) begin
          s[4*c]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
          s[4*c+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
          s[4*c+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
          s[4*c+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
        end else begin
          s[4*c] = a0; s[4*c+1] = a1; s[4*c+2] = a2; s[4*c+3] = a3;
        end
      end
      for (int i = 0; i < 16; i++) s[i] ^= w[16*rd+i];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  // Cycle-level reference model of the handshake and latency.
  int m_cnt = 0;
  bit m_ov = 0;
  logic [127:0] m_ct = '0, m_pend = '0;
  wire exp_rdy = (m_cnt == 0) && (!m_ov || out_ready);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_ov <= 0;
    end else begin
      if (m_ov && out_ready) m_ov <= 0;
      if (m_cnt != 0) begin
        if (m_cnt == 10) begin m_cnt <= 0; m_ov <= 1; m_ct <= m_pend; end
        else m_cnt <= m_cnt + 1;
      end
      if (in_valid && exp_rdy) begin
        m_cnt <= 1;
        m_pend <= ref_enc(in_text, in_key);
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk(in_ready == exp_rdy, "R2 in_ready vs model", 128'(in_ready), 128'(exp_rdy));
      chk(out_valid == m_ov, "R3 out_valid vs model", 128'(out_valid), 128'(m_ov));
      if (out_valid && m_ov) chk(out_text == m_ct, "R8 out_text vs model", out_text, m_ct);
    end
  end

  always @(negedge clk) if (rand_rdy) out_ready <= 1'($urandom % 2);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  int acc_cyc;

  task automatic send(input logic [127:0] pt, input logic [127:0] k);
    @(negedge clk);
    in_valid = 1; in_text = pt; in_key = k;
    forever begin
      #2;
      if (in_ready) break;
      @(negedge clk);
    end
    acc_cyc = cyc + 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_valid();
    forever begin
      #2;
      if (out_valid) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_take(input logic [127:0] exp, input string req);
    forever begin
      @(negedge clk); #2;
      if (out_valid && out_ready) break;
    end
    chk(out_text == exp, req, out_text, exp);
  endtask

  initial begin
    logic [127:0] pa, ka, pb, kb, pc, kc, held;
    init_sbox();
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R1 in_ready in reset", 128'(in_ready), 128'd1);
    chk(out_valid == 1'b0, "R1 out_valid in reset", 128'(out_valid), 128'd0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 after reset",
        {126'd0, in_ready, out_valid}, 128'd2);

    // R4 known answer and R3 latency
    out_ready = 1;
    send(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f);
    wait_valid();
    chk(cyc == acc_cyc + 10, "R3 latency", 128'(cyc), 128'(acc_cyc + 10));
    chk(out_text == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R4 known answer",
        out_text, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    @(negedge clk);

    // R7: offers while busy are ignored
    pa = {$urandom, $urandom, $urandom, $urandom};
    ka = {$urandom, $urandom, $urandom, $urandom};
    send(pa, ka);
    for (int i = 0; i < 5; i++) begin
      in_valid = 1; in_text = ~pa; in_key = ka ^ 128'(i + 1);
      #1;
      chk(in_ready == 1'b0, "R2 busy not ready", 128'(in_ready), 128'd0);
      @(negedge clk);
    end
    in_valid = 0;
    wait_take(ref_enc(pa, ka), "R7 busy offers ignored");
    @(negedge clk);

    // R5: hold under back-pressure
    out_ready = 0;
    pb = {$urandom, $urandom, $urandom, $urandom};
    kb = {$urandom, $urandom, $urandom, $urandom};
    send(pb, kb);
    wait_valid();
    held = out_text;
    chk(held == ref_enc(pb, kb), "R4 stalled result", held, ref_enc(pb, kb));
    repeat (5) @(negedge clk);
    #1;
    chk(out_valid == 1'b1 && out_text == held, "R5 held result", out_text, held);
    chk(in_ready == 1'b0, "R2 stalled not ready", 128'(in_ready), 128'd0);

    // R6: take and accept on the same edge
    pc = {$urandom, $urandom, $urandom, $urandom};
    kc = {$urandom, $urandom, $urandom, $urandom};
    in_valid = 1; in_text = pc; in_key = kc;
    #1;
    chk(in_ready == 1'b0, "R6 not ready before take", 128'(in_ready), 128'd0);
    @(negedge clk);
    out_ready = 1;
    #1;
    chk(in_ready == 1'b1 && out_valid == 1'b1, "R6 ready with take",
        {126'd0, in_ready, out_valid}, 128'd3);
    @(negedge clk);
    in_valid = 0;
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b0, "R6 taken and busy",
        {126'd0, in_ready, out_valid}, 128'd0);
    wait_take(ref_enc(pc, kc), "R6 overlapped block");

    // R8: random vectors under random back-pressure
    rand_rdy = 1;
    for (int v = 0; v < 12; v++) begin
      logic [127:0] p, k;
      p = {$urandom, $urandom, $urandom, $urandom};
      k = {$urandom, $urandom, $urandom, $urandom};
      if (v == 0) k = '1;
      if (v == 1) p = '0;
      send(p, k);
      wait_take(ref_enc(p, k), "R8 random vector");
    end
    rand_rdy = 0;
    repeat (4) @(negedge clk);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule